// File: doc/BRIEF.md
# Write-Through Data Cache with Split-Line Validity

This block holds the tags, valid bits and data of a direct-mapped level-one data cache. It takes one load or one store per cycle and answers on the following cycle. The requester supplies a line index, which comes from untranslated address bits, together with the physical tag of the access. The cache compares that tag against the stored one. Each line is made of two 16-byte halves. Each half carries its own valid bit, so a line can be partly present.

Stores never allocate a line. Every store, hit or miss, is passed to a write-out interface. A store that hits also updates the cached half, limited to the bytes its byte mask enables. A load that misses is reported on a miss interface. The requested data comes back later through the fill port, which writes one half per cycle.

A second tag port serves both the fills and the snoop invalidations from the rest of the system. The request port therefore never waits for either of them. When a snoop and a fill hit the same line in the same cycle, the snoop wins.

Top module: `wt_dcache`

## Requirements
- R1: Each cycle accepts at most one request. A load (req_valid=1, req_write=0) produces ld_valid=1 in the following cycle, and no write-out is issued for it.
- R2: A load hits (ld_hit=1, ld_data = stored half) only when the stored tag of the indexed line equals req_tag and the valid bit of the half selected by req_sub (0 = lower half, 1 = upper half) is set. Otherwise ld_hit=0 and ld_data=0.
- R3: A load that misses raises miss_valid in the same cycle as its ld_valid. miss_index, miss_sub and miss_tag repeat the request fields. miss_valid is never high without a missed load.
- R4: Every store (req_write=1) produces wt_valid=1 in the following cycle. wt_index, wt_sub, wt_tag, wt_data and wt_be equal the request fields.
- R5: A store that hits replaces only the enabled bytes of the cached half. Byte-enable bit i covers data bits [8i+7:8i].
- R6: A store that misses leaves tags, valid bits and data unchanged.
- R7: A fill writes its 16-byte half, writes the line tag and sets that half's valid bit. A later load to that half and tag returns the fill data.
- R8: A fill whose tag differs from the stored tag clears the other half's valid bit. A fill with the same tag leaves the other half's valid bit as it was.
- R9: A snoop whose index selects a line holding a valid half with an equal tag clears both valid bits, effective from the next cycle. A snoop with an unequal tag has no effect.
- R10: When a snoop and a fill name the same index in the same cycle, and the snoop tag equals either the stored tag or the fill tag, both halves end invalid.
- R11: A load in the same cycle as a fill or a snoop is answered in the following cycle, from the state held before that cycle's updates.
- R12: After reset every half is invalid, and ld_valid, miss_valid and wt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_index | input | IDX_W | Line index from untranslated address bits |
| req_sub | input | 1 | Half of the line (0 lower, 1 upper) |
| req_tag | input | TAG_W | Physical tag to compare |
| req_wdata | input | 128 | Store data |
| req_be | input | 16 | Store byte enables |
| fill_valid | input | 1 | Fill present this cycle |
| fill_index | input | IDX_W | Fill line index |
| fill_sub | input | 1 | Fill half |
| fill_tag | input | TAG_W | Fill tag |
| fill_data | input | 128 | Fill data |
| snp_valid | input | 1 | Snoop invalidate present |
| snp_index | input | IDX_W | Snoop line index |
| snp_tag | input | TAG_W | Snoop tag |
| ld_valid | output | 1 | Load result valid |
| ld_hit | output | 1 | Load hit |
| ld_data | output | 128 | Load data on a hit, zero on a miss |
| miss_valid | output | 1 | Load miss request |
| miss_index | output | IDX_W | Missed index |
| miss_sub | output | 1 | Missed half |
| miss_tag | output | TAG_W | Missed tag |
| wt_valid | output | 1 | Write-through request |
| wt_index | output | IDX_W | Store index |
| wt_sub | output | 1 | Store half |
| wt_tag | output | TAG_W | Store tag |
| wt_data | output | 128 | Store data |
| wt_be | output | 16 | Store byte enables |

## Verification
The bench builds the cache with CACHE_BYTES=256 and TAG_W=8, which gives eight lines and a 3-bit index. With so few lines, tag replacement in a single line is easy to provoke, and so are sibling-half invalidation and aliasing between tags that differ. The halves, byte masks and port timing stay the same as in the full-size build, so the same-cycle snoop, fill and load cases behave as they do at the default size.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int SUB_BYTES = 16;
    localparam int SUBS      = 2;
    localparam int DATA_W    = SUB_BYTES * 8;

    typedef logic [DATA_W-1:0]    sub_data_t;
    typedef logic [SUB_BYTES-1:0] sub_be_t;
    typedef logic [SUBS-1:0]      sub_vld_t;

    function automatic sub_data_t merge_bytes(input sub_data_t old_d,
                                              input sub_data_t new_d,
                                              input sub_be_t   be);
        sub_data_t r;
        r = old_d;
        for (int b = 0; b < SUB_BYTES; b++) begin
            if (be[b]) r[b*8 +: 8] = new_d[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic sub_vld_t half_bit(input logic s);
        sub_vld_t r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store import dc_pkg::*; #(
    parameter int LINES = 512,
    parameter int IDX_W = 9,
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_index,
    output logic [TAG_W-1:0] rd_tag,
    output sub_vld_t         rd_vld,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             fill_sub,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_index,
    input  logic [TAG_W-1:0] snp_tag
);
    logic [TAG_W-1:0] tag_q [LINES];
    sub_vld_t         vld_q [LINES];

    logic     snp_kill;
    logic     fill_new_tag;
    sub_vld_t fill_vld_next;

    // port 1: request lookup
    assign rd_tag = tag_q[rd_index];
    assign rd_vld = vld_q[rd_index];

    // port 2: snoop lookup and fill update
    always_comb begin
        snp_kill = snp_valid &&
                   (((tag_q[snp_index] == snp_tag) && (|vld_q[snp_index])) ||
                    (fill_valid && (fill_index == snp_index) && (fill_tag == snp_tag)));
        fill_new_tag  = tag_q[fill_index] != fill_tag;
        fill_vld_next = (fill_new_tag ? sub_vld_t'('0) : vld_q[fill_index])
                        | half_bit(fill_sub);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else begin
            if (fill_valid) begin
                tag_q[fill_index] <= fill_tag;
                vld_q[fill_index] <= fill_vld_next;
            end
            if (snp_kill) vld_q[snp_index] <= '0;   // snoop wins over fill
        end
    end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store import dc_pkg::*; #(
    parameter int LINES = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_index,
    input  logic             rd_sub,
    output sub_data_t        rd_data,
    input  logic             st_en,
    input  sub_data_t        st_data,
    input  sub_be_t          st_be,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             fill_sub,
    input  sub_data_t        fill_data
);
    localparam int ENTRIES = LINES * SUBS;
    localparam int ADDR_W  = IDX_W + 1;

    sub_data_t mem_q [ENTRIES];

    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] fill_addr;

    assign rd_addr   = {rd_index, rd_sub};
    assign fill_addr = {fill_index, fill_sub};
    assign rd_data   = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (st_en)   mem_q[rd_addr]   <= merge_bytes(mem_q[rd_addr], st_data, st_be);
        if (fill_en) mem_q[fill_addr] <= fill_data;   // fill wins on collision
    end
endmodule

// File: rtl/dc_resp_reg.sv
module dc_resp_reg import dc_pkg::*; #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_sub,
    input  logic [TAG_W-1:0] req_tag,
    input  sub_data_t        req_wdata,
    input  sub_be_t          req_be,
    input  logic             hit,
    input  sub_data_t        hit_data,
    output logic             ld_valid,
    output logic             ld_hit,
    output sub_data_t        ld_data,
    output logic             miss_valid,
    output logic [IDX_W-1:0] miss_index,
    output logic             miss_sub,
    output logic [TAG_W-1:0] miss_tag,
    output logic             wt_valid,
    output logic [IDX_W-1:0] wt_index,
    output logic             wt_sub,
    output logic [TAG_W-1:0] wt_tag,
    output sub_data_t        wt_data,
    output sub_be_t          wt_be
);
    logic is_load, is_store;
    assign is_load  = req_valid && !req_write;
    assign is_store = req_valid &&  req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid   <= 1'b0;
            ld_hit     <= 1'b0;
            ld_data    <= '0;
            miss_valid <= 1'b0;
            miss_index <= '0;
            miss_sub   <= 1'b0;
            miss_tag   <= '0;
            wt_valid   <= 1'b0;
            wt_index   <= '0;
            wt_sub     <= 1'b0;
            wt_tag     <= '0;
            wt_data    <= '0;
            wt_be      <= '0;
        end else begin
            ld_valid   <= is_load;
            ld_hit     <= is_load && hit;
            ld_data    <= (is_load && hit) ? hit_data : '0;
            miss_valid <= is_load && !hit;
            miss_index <= req_index;
            miss_sub   <= req_sub;
            miss_tag   <= req_tag;
            wt_valid   <= is_store;
            wt_index   <= req_index;
            wt_sub     <= req_sub;
            wt_tag     <= req_tag;
            wt_data    <= req_wdata;
            wt_be      <= req_be;
        end
    end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache import dc_pkg::*; #(
    parameter int CACHE_BYTES = 16384,
    parameter int TAG_W       = 28,
    localparam int LINES      = CACHE_BYTES / (SUB_BYTES * SUBS),
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_sub,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [127:0]     req_wdata,
    input  logic [15:0]      req_be,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             fill_sub,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [127:0]     fill_data,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_index,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             ld_valid,
    output logic             ld_hit,
    output logic [127:0]     ld_data,
    output logic             miss_valid,
    output logic [IDX_W-1:0] miss_index,
    output logic             miss_sub,
    output logic [TAG_W-1:0] miss_tag,
    output logic             wt_valid,
    output logic [IDX_W-1:0] wt_index,
    output logic             wt_sub,
    output logic [TAG_W-1:0] wt_tag,
    output logic [127:0]     wt_data,
    output logic [15:0]      wt_be
);
    logic [TAG_W-1:0] look_tag;
    sub_vld_t         look_vld;
    sub_data_t        look_data;
    logic             hit;
    logic             store_hit;

    assign hit       = (look_tag == req_tag) && look_vld[req_sub];
    assign store_hit = req_valid && req_write && hit;

    dc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .rd_index   (req_index),
        .rd_tag     (look_tag),
        .rd_vld     (look_vld),
        .fill_valid (fill_valid),
        .fill_index (fill_index),
        .fill_sub   (fill_sub),
        .fill_tag   (fill_tag),
        .snp_valid  (snp_valid),
        .snp_index  (snp_index),
        .snp_tag    (snp_tag)
    );

    dc_data_store #(.LINES(LINES), .IDX_W(IDX_W)) u_data (
        .clk        (clk),
        .rd_index   (req_index),
        .rd_sub     (req_sub),
        .rd_data    (look_data),
        .st_en      (store_hit),
        .st_data    (req_wdata),
        .st_be      (req_be),
        .fill_en    (fill_valid),
        .fill_index (fill_index),
        .fill_sub   (fill_sub),
        .fill_data  (fill_data)
    );

    dc_resp_reg #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_index  (req_index),
        .req_sub    (req_sub),
        .req_tag    (req_tag),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .hit        (hit),
        .hit_data   (look_data),
        .ld_valid   (ld_valid),
        .ld_hit     (ld_hit),
        .ld_data    (ld_data),
        .miss_valid (miss_valid),
        .miss_index (miss_index),
        .miss_sub   (miss_sub),
        .miss_tag   (miss_tag),
        .wt_valid   (wt_valid),
        .wt_index   (wt_index),
        .wt_sub     (wt_sub),
        .wt_tag     (wt_tag),
        .wt_data    (wt_data),
        .wt_be      (wt_be)
    );
endmodule

// File: rtl/dc_checks.sv
module dc_checks #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 28
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [IDX_W-1:0] req_index,
    input logic             req_sub,
    input logic [TAG_W-1:0] req_tag,
    input logic [127:0]     req_wdata,
    input logic [15:0]      req_be,
    input logic             ld_valid,
    input logic             ld_hit,
    input logic             miss_valid,
    input logic [IDX_W-1:0] miss_index,
    input logic             miss_sub,
    input logic [TAG_W-1:0] miss_tag,
    input logic             wt_valid,
    input logic [IDX_W-1:0] wt_index,
    input logic             wt_sub,
    input logic [TAG_W-1:0] wt_tag,
    input logic [127:0]     wt_data,
    input logic [15:0]      wt_be
);
    a_r1_load_answered: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (ld_valid && !wt_valid));

    a_r1_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_valid, wt_valid}));

    a_r3_miss_only_on_missed_load: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> (ld_valid && !ld_hit));

    a_r3_miss_fields: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> ((miss_valid == !ld_hit) &&
            (!miss_valid || (miss_index == $past(req_index) &&
                             miss_sub == $past(req_sub) && miss_tag == $past(req_tag)))));

    a_r4_store_through: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (wt_valid && !ld_valid &&
            wt_index == $past(req_index) && wt_sub == $past(req_sub) &&
            wt_tag == $past(req_tag) && wt_data == $past(req_wdata) &&
            wt_be == $past(req_be)));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!ld_valid && !wt_valid && !miss_valid));
endmodule

bind wt_dcache dc_checks #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_index  (req_index),
    .req_sub    (req_sub),
    .req_tag    (req_tag),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .ld_valid   (ld_valid),
    .ld_hit     (ld_hit),
    .miss_valid (miss_valid),
    .miss_index (miss_index),
    .miss_sub   (miss_sub),
    .miss_tag   (miss_tag),
    .wt_valid   (wt_valid),
    .wt_index   (wt_index),
    .wt_sub     (wt_sub),
    .wt_tag     (wt_tag),
    .wt_data    (wt_data),
    .wt_be      (wt_be)
);

// File: tb/tb_wt_dcache.sv
module tb_wt_dcache;
    localparam int IW = 3;
    localparam int TW = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid, req_write, req_sub;
    logic [IW-1:0]  req_index;
    logic [TW-1:0]  req_tag;
    logic [127:0]   req_wdata;
    logic [15:0]    req_be;
    logic           fill_valid, fill_sub;
    logic [IW-1:0]  fill_index;
    logic [TW-1:0]  fill_tag;
    logic [127:0]   fill_data;
    logic           snp_valid;
    logic [IW-1:0]  snp_index;
    logic [TW-1:0]  snp_tag;
    logic           ld_valid, ld_hit, miss_valid, miss_sub, wt_valid, wt_sub;
    logic [127:0]   ld_data, wt_data;
    logic [IW-1:0]  miss_index, wt_index;
    logic [TW-1:0]  miss_tag, wt_tag;
    logic [15:0]    wt_be;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    wt_dcache #(.CACHE_BYTES(256), .TAG_W(TW)) dut (.*);

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_index = '0; req_sub = 0; req_tag = '0;
        req_wdata = '0; req_be = '0;
        fill_valid = 0; fill_index = '0; fill_sub = 0; fill_tag = '0; fill_data = '0;
        snp_valid = 0; snp_index = '0; snp_tag = '0;
    endtask

    // inputs set before calling; completes one clock, samples after the edge
    task automatic step();
        @(posedge clk); #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_load(input logic [IW-1:0] i, input logic s, input logic [TW-1:0] t);
        req_valid = 1; req_write = 0; req_index = i; req_sub = s; req_tag = t;
    endtask

    task automatic set_fill(input logic [IW-1:0] i, input logic s, input logic [TW-1:0] t,
                            input logic [127:0] d);
        fill_valid = 1; fill_index = i; fill_sub = s; fill_tag = t; fill_data = d;
    endtask

    task automatic set_snoop(input logic [IW-1:0] i, input logic [TW-1:0] t);
        snp_valid = 1; snp_index = i; snp_tag = t;
    endtask

    task automatic expect_load(input logic [IW-1:0] i, input logic s, input logic [TW-1:0] t,
                               input logic hit, input logic [127:0] d, input string req);
        set_load(i, s, t);
        @(posedge clk); #1;
        chk(ld_valid == 1'b1, {req, " ld_valid"}, 128'(ld_valid), 128'd1);
        chk(ld_hit == hit, {req, " ld_hit"}, 128'(ld_hit), 128'(hit));
        chk(ld_data == (hit ? d : 128'd0), {req, " ld_data"}, ld_data, hit ? d : 128'd0);
        chk(miss_valid == !hit, {req, " R3 miss_valid"}, 128'(miss_valid), 128'(!hit));
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic logic [127:0] mrg(input logic [127:0] o, input logic [127:0] n,
                                        input logic [15:0] be);
        logic [127:0] r;
        r = o;
        for (int b = 0; b < 16; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    localparam logic [127:0] DA = {4{32'hA1A2_A3A4}};
    localparam logic [127:0] DB = {4{32'hB1B2_B3B4}};
    localparam logic [127:0] DC = {4{32'hC1C2_C3C4}};
    localparam logic [127:0] DD = {4{32'hD1D2_D3D4}};
    localparam logic [127:0] DE = {4{32'hE1E2_E3E4}};
    localparam logic [127:0] DF = {4{32'hF1F2_F3F4}};

    task automatic t_reset();
        chk(!ld_valid && !miss_valid && !wt_valid, "R12 outputs idle after reset",
            128'({ld_valid, miss_valid, wt_valid}), 128'd0);
        set_load(3'd0, 1'b0, 8'h5A);
        @(posedge clk); #1;
        chk(ld_valid && !ld_hit && miss_valid, "R12 line invalid after reset",
            128'({ld_valid, ld_hit, miss_valid}), 128'b101);
        chk(miss_index == 3'd0 && miss_sub == 1'b0 && miss_tag == 8'h5A, "R3 miss fields",
            128'({miss_index, miss_sub, miss_tag}), 128'({3'd0, 1'b0, 8'h5A}));
        @(negedge clk); idle_inputs();
    endtask

    task automatic t_fill_and_hit();
        set_fill(3'd1, 1'b0, 8'h11, DA); step();
        expect_load(3'd1, 1'b0, 8'h11, 1'b1, DA, "R7 fill then load hits");
        expect_load(3'd1, 1'b1, 8'h11, 1'b0, 0, "R2 other half not valid");
        expect_load(3'd1, 1'b0, 8'h12, 1'b0, 0, "R2 tag mismatch misses");
    endtask

    task automatic t_fill_tags();
        set_fill(3'd1, 1'b1, 8'h11, DB); step();
        expect_load(3'd1, 1'b0, 8'h11, 1'b1, DA, "R8 same tag keeps sibling");
        expect_load(3'd1, 1'b1, 8'h11, 1'b1, DB, "R7 upper half fill");
        set_fill(3'd1, 1'b0, 8'h22, DC); step();
        expect_load(3'd1, 1'b1, 8'h22, 1'b0, 0, "R8 new tag clears sibling");
        expect_load(3'd1, 1'b1, 8'h11, 1'b0, 0, "R8 old tag gone");
        expect_load(3'd1, 1'b0, 8'h22, 1'b1, DC, "R7 replaced half");
    endtask

    task automatic t_stores();
        req_valid = 1; req_write = 1; req_index = 3'd1; req_sub = 1'b0; req_tag = 8'h22;
        req_wdata = DD; req_be = 16'h00F3;
        @(posedge clk); #1;
        chk(wt_valid && !ld_valid, "R4 store hit written through",
            128'({wt_valid, ld_valid}), 128'b10);
        chk(wt_index == 3'd1 && wt_sub == 1'b0 && wt_tag == 8'h22 && wt_be == 16'h00F3,
            "R4 write-out fields", 128'({wt_index, wt_sub, wt_tag, wt_be}),
            128'({3'd1, 1'b0, 8'h22, 16'h00F3}));
        chk(wt_data == DD, "R4 write-out data", wt_data, DD);
        @(negedge clk); idle_inputs();
        expect_load(3'd1, 1'b0, 8'h22, 1'b1, mrg(DC, DD, 16'h00F3), "R5 byte-masked merge");
        // store miss on a different tag in the same line
        req_valid = 1; req_write = 1; req_index = 3'd1; req_sub = 1'b0; req_tag = 8'h44;
        req_wdata = DE; req_be = 16'hFFFF;
        @(posedge clk); #1;
        chk(wt_valid && wt_tag == 8'h44, "R4 store miss written through",
            128'({wt_valid, wt_tag}), 128'({1'b1, 8'h44}));
        @(negedge clk); idle_inputs();
        expect_load(3'd1, 1'b0, 8'h22, 1'b1, mrg(DC, DD, 16'h00F3), "R6 store miss leaves line");
        expect_load(3'd1, 1'b0, 8'h44, 1'b0, 0, "R6 store miss no allocate");
        req_valid = 1; req_write = 1; req_index = 3'd2; req_sub = 1'b1; req_tag = 8'h33;
        req_wdata = DE; req_be = 16'hFFFF;
        step();
        expect_load(3'd2, 1'b1, 8'h33, 1'b0, 0, "R6 store to empty line no allocate");
    endtask

    task automatic t_snoop();
        set_fill(3'd1, 1'b1, 8'h22, DE); step();
        set_snoop(3'd1, 8'h55); step();
        expect_load(3'd1, 1'b1, 8'h22, 1'b1, DE, "R9 unequal snoop no effect");
        set_snoop(3'd1, 8'h22); step();
        expect_load(3'd1, 1'b0, 8'h22, 1'b0, 0, "R9 snoop clears lower half");
        expect_load(3'd1, 1'b1, 8'h22, 1'b0, 0, "R9 snoop clears upper half");
    endtask

    task automatic t_snoop_fill();
        set_fill(3'd3, 1'b0, 8'h66, DA); set_snoop(3'd3, 8'h66); step();
        expect_load(3'd3, 1'b0, 8'h66, 1'b0, 0, "R10 snoop beats fill on fill tag");
        set_fill(3'd4, 1'b0, 8'h77, DB); step();
        set_fill(3'd4, 1'b1, 8'h77, DC); set_snoop(3'd4, 8'h77); step();
        expect_load(3'd4, 1'b0, 8'h77, 1'b0, 0, "R10 snoop beats fill lower");
        expect_load(3'd4, 1'b1, 8'h77, 1'b0, 0, "R10 snoop beats fill upper");
    endtask

    task automatic t_concurrent();
        set_fill(3'd5, 1'b0, 8'h12, DF); step();
        set_snoop(3'd5, 8'h12);
        expect_load(3'd5, 1'b0, 8'h12, 1'b1, DF, "R11 load beside snoop not held");
        expect_load(3'd5, 1'b0, 8'h12, 1'b0, 0, "R9 snoop took effect next cycle");
        set_fill(3'd6, 1'b1, 8'h34, DA);
        expect_load(3'd6, 1'b1, 8'h34, 1'b0, 0, "R11 load beside fill sees old state");
        expect_load(3'd6, 1'b1, 8'h34, 1'b1, DA, "R11 fill visible afterwards");
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_fill_and_hit();
        t_fill_tags();
        t_stores();
        t_snoop();
        t_snoop_fill();
        t_concurrent();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule